// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the bus interface of a small 8-bit processor with a 16-bit address space. It runs one machine cycle at a time. The cycle kinds are opcode fetch, memory read, memory write, port read, port write and interrupt acknowledge. The address low byte and the data share one 8-bit lane. In the first clock the block drives the address onto that lane and pulses an address-latch strobe, so an external latch can hold the low byte. In the following clocks the same lane carries the data. Each cycle kind has a three-bit status code. A slow target can stretch the data phase by holding `ready` low. An external master can take the bus with `hold`.

Requests arrive on a valid/ready channel. A request transfers on a rising clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the sequencer is idle and `hold` is low, so a sender simply waits while a cycle runs or while the bus is handed over. The kind, address and write data are sampled at that edge, and later changes have no effect. Completion is reported by a single-clock `rsp_valid` pulse carrying `rsp_data`. It has no back-pressure, so the consumer must take it in that clock.

Top module: `bus_cycle_seq`

## Requirements
- R1: Out of reset, and while idle, `rd_n`, `wr_n` and `inta_n` are high, `ale`, `hlda` and `rsp_valid` are low, and `req_ready` is high when `hold` is low.
- R2: In the first clock after acceptance (T1), `ale` is high for exactly that clock. `ad_oe` is high with the low address byte on `ad_out`, and `a_hi` carries the high byte. For port cycles (kind 3 or 4), both `ad_out` and `a_hi` carry the 8-bit port number `req_addr[7:0]`.
- R3: From T1 to the last strobe clock, {`io_m`,`s1`,`s0`} are as follows: 0,1,1 for kind 0 (opcode fetch); 0,1,0 for kind 1 (memory read); 0,0,1 for kind 2 (memory write); 1,1,0 for kind 3 (port read); 1,0,1 for kind 4 (port write); 1,1,1 for kind 5 (interrupt acknowledge).
- R4: With no wait states, kinds 1 to 4 take three clocks (T1..T3). Kinds 0 and 5 take four clocks, and the fourth clock has no strobe. `rsp_valid` rises in the clock after the last T-state.
- R5: The strobe is low from T2 through T3. Kinds 0, 1 and 3 use `rd_n`, kinds 2 and 4 use `wr_n`, and kind 5 uses `inta_n` with `rd_n` staying high. At most one strobe is low at a time.
- R6: `ready` is sampled at the end of T2 and at the end of each wait clock. Each low sample adds one whole clock with the strobe and status held.
- R7: For write kinds, `ad_oe` is high with the write data on `ad_out` for as long as `wr_n` is low. For read kinds, `ad_oe` is low while the strobe is low.
- R8: For read kinds, `rsp_data` is the value on `ad_in` in the last clock the strobe is low, that is, at the strobe's rising edge.
- R9: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low during a cycle and while `hold` is high. Request inputs that change after acceptance do not affect the running cycle.
- R10: A `hold` that rises during a cycle lets that cycle finish. The bus is then floated: `bus_oe` and `ad_oe` are low, the strobes are high, `ale` is low, and `hlda` is high. `hlda` falls one clock after `hold` falls, and requests are then accepted again.
- R11: `rsp_valid` is high for exactly one clock per machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_kind | input | 3 | Cycle kind code (0..5, see R3) |
| req_addr | input | 16 | Memory address or, in bits 7:0, port number |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_data | output | 8 | Captured read data |
| ready | input | 1 | Target ready; low inserts wait clocks |
| hold | input | 1 | External bus request |
| hlda | output | 1 | Bus handed over |
| a_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared lane, driven value |
| ad_in | input | 8 | Shared lane, sampled value |
| ad_oe | output | 1 | Drive enable for the shared lane |
| bus_oe | output | 1 | Drive enable for high address, status and strobes |
| ale | output | 1 | Address latch strobe |
| io_m | output | 1 | Status: port (1) or memory (0) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |

## Verification
A corrupted T-state register shows up at the pins within one clock. It produces a second `ale` pulse, a strobe that starts early or ends late, or a strobe window that does not match the count of low `ready` samples. A wrongly latched kind shows up in T1 as a wrong status code or wrong address bytes, and then as the wrong strobe in T2. A capture edge off by one clock is seen at completion, because the bench drives the expected read byte on `ad_in` only in the final strobe clock. Hold mishandling appears in the first clock after the interrupted cycle ends, as `hlda` low or the bus still driven.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [2:0] {
    K_FETCH  = 3'd0,
    K_MEMRD  = 3'd1,
    K_MEMWR  = 3'd2,
    K_IORD   = 3'd3,
    K_IOWR   = 3'd4,
    K_INTACK = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE, TS_T1, TS_T2, TS_TW, TS_T3, TS_T4, TS_HOLD
  } tstate_e;

  // Per-kind attributes: status code plus strobe and length selection
  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
    logic is_write;
    logic use_inta;
    logic four_t;
    logic is_io;
  } cyc_attr_t;
endpackage

// File: rtl/bseq_kind_decode.sv
module bseq_kind_decode
  import bseq_pkg::*;
(
  input  kind_e     kind,
  output cyc_attr_t attr
);
  always_comb begin
    attr = '0;
    case (kind)
      K_FETCH:  begin attr.s1 = 1'b1; attr.s0 = 1'b1; attr.four_t = 1'b1; end
      K_MEMRD:  begin attr.s1 = 1'b1; end
      K_MEMWR:  begin attr.s0 = 1'b1; attr.is_write = 1'b1; end
      K_IORD:   begin attr.io_m = 1'b1; attr.s1 = 1'b1; attr.is_io = 1'b1; end
      K_IOWR:   begin attr.io_m = 1'b1; attr.s0 = 1'b1; attr.is_io = 1'b1;
                      attr.is_write = 1'b1; end
      K_INTACK: begin attr.io_m = 1'b1; attr.s1 = 1'b1; attr.s0 = 1'b1;
                      attr.use_inta = 1'b1; attr.four_t = 1'b1; end
      default:  begin attr.s1 = 1'b1; end  // undefined codes behave as memory read
    endcase
  end
endmodule

// File: rtl/bseq_tstate.sv
module bseq_tstate
  import bseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    four_t,
  input  logic    ready,
  input  logic    hold,
  output tstate_e state,
  output logic    last
);
  tstate_e nxt;

  assign last = (state == TS_T3 && !four_t) || (state == TS_T4);

  always_comb begin
    nxt = state;
    case (state)
      TS_IDLE: if (hold) nxt = TS_HOLD; else if (start) nxt = TS_T1;
      TS_T1:   nxt = TS_T2;
      TS_T2,
      TS_TW:   nxt = ready ? TS_T3 : TS_TW;
      TS_T3:   nxt = four_t ? TS_T4 : (hold ? TS_HOLD : TS_IDLE);
      TS_T4:   nxt = hold ? TS_HOLD : TS_IDLE;
      TS_HOLD: nxt = hold ? TS_HOLD : TS_IDLE;
      default: nxt = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= TS_IDLE;
    else        state <= nxt;
endmodule

// File: rtl/bseq_datapath.sv
module bseq_datapath
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic              finish,
  input  logic [DATA_W-1:0] ad_in,
  output cyc_attr_t         attr,
  output logic [DATA_W-1:0] addr_lo,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_valid
);
  localparam int HI_W = ADDR_W - DATA_W;

  kind_e     kind_q;
  cyc_attr_t in_attr;

  bseq_kind_decode u_dec_in  (.kind(kind_e'(req_kind)), .attr(in_attr));
  bseq_kind_decode u_dec_cur (.kind(kind_q),            .attr(attr));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      kind_q  <= K_FETCH;
      addr_lo <= '0;
      addr_hi <= '0;
      wdata_q <= '0;
    end else if (load) begin
      kind_q  <= kind_e'(req_kind);
      addr_lo <= req_addr[DATA_W-1:0];
      // Port cycles repeat the port number on the high byte
      addr_hi <= in_attr.is_io ? HI_W'(req_addr[DATA_W-1:0])
                               : req_addr[ADDR_W-1:DATA_W];
      wdata_q <= req_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_data  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      if (capture) rsp_data <= ad_in;
      rsp_valid <= finish;
    end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  input  logic                     ready,
  input  logic                     hold,
  output logic                     hlda,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0]        ad_out,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ad_oe,
  output logic                     bus_oe,
  output logic                     ale,
  output logic                     io_m,
  output logic                     s1,
  output logic                     s0,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     inta_n
);
  localparam int HI_W = ADDR_W - DATA_W;

  tstate_e   state;
  logic      last, start, busy, strobe_win;
  cyc_attr_t attr;
  logic [DATA_W-1:0] addr_lo, wdata_q;
  logic [HI_W-1:0]   addr_hi;

  assign req_ready  = (state == TS_IDLE) && !hold;
  assign start      = req_valid && req_ready;
  assign strobe_win = (state == TS_T2) || (state == TS_TW) || (state == TS_T3);
  assign busy       = strobe_win || (state == TS_T1) || (state == TS_T4);

  bseq_tstate u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .four_t(attr.four_t),
    .ready(ready), .hold(hold), .state(state), .last(last)
  );

  bseq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(start), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .capture((state == TS_T3) && !attr.is_write),
    .finish(last), .ad_in(ad_in), .attr(attr), .addr_lo(addr_lo),
    .addr_hi(addr_hi), .wdata_q(wdata_q), .rsp_data(rsp_data),
    .rsp_valid(rsp_valid)
  );

  always_comb begin
    hlda   = (state == TS_HOLD);
    bus_oe = !hlda;
    ale    = (state == TS_T1);
    a_hi   = busy ? addr_hi : '0;
    {io_m, s1, s0} = busy ? {attr.io_m, attr.s1, attr.s0} : 3'b000;
    rd_n   = !(strobe_win && !attr.is_write && !attr.use_inta);
    wr_n   = !(strobe_win && attr.is_write);
    inta_n = !(strobe_win && attr.use_inta);
    ad_oe  = ale || (strobe_win && attr.is_write);
    if (ale)                              ad_out = addr_lo;
    else if (strobe_win && attr.is_write) ad_out = wdata_q;
    else                                  ad_out = '0;
  end
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic hlda,
  input logic ad_oe,
  input logic bus_oe,
  input logic ale,
  input logic io_m,
  input logic s1,
  input logic s0,
  input logic rd_n,
  input logic wr_n,
  input logic inta_n
);
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_ale_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && bus_oe));
  assert_status_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n || !inta_n) |-> $stable({io_m, s1, s0}));
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);
  assert_strobe_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n) || $fell(inta_n)) |=> (!rd_n || !wr_n || !inta_n));
  assert_write_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);
  assert_read_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !inta_n) |-> !ad_oe);
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!hlda && rd_n && wr_n && inta_n && !ale));
  assert_float_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (rd_n && wr_n && inta_n && !ale && !ad_oe && !bus_oe && !req_ready));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (.*);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, ready = 1'b1, hold = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0] req_wdata = 8'h0, ad_in = 8'h0;
  logic req_ready, rsp_valid, hlda, ad_oe, bus_oe, ale, io_m, s1, s0, rd_n, wr_n, inta_n;
  logic [7:0] rsp_data, a_hi, ad_out;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ready(ready), .hold(hold),
    .hlda(hlda), .a_hi(a_hi), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe),
    .bus_oe(bus_oe), .ale(ale), .io_m(io_m), .s1(s1), .s0(s0),
    .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] status_of(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      3'd4: return 3'b101;
      default: return 3'b111;
    endcase
  endfunction

  task automatic test_reset();
    @(negedge clk);
    check({rd_n, wr_n, inta_n} === 3'b111, "R1 strobes idle", {rd_n, wr_n, inta_n}, 3'b111);
    check({ale, hlda, rsp_valid} === 3'b000, "R1 ale/hlda/done idle", {ale, hlda, rsp_valid}, 3'b000);
    check(req_ready === 1'b1, "R1 req_ready idle", req_ready, 1);
  endtask

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                           input logic [7:0] rdv, input int w, input bit hold_mid);
    bit four, isw, isio, inta;
    int last_i;
    logic [7:0] hi_e;
    logic [2:0] strb_e;
    four = (k == 3'd0) || (k == 3'd5);
    isw  = (k == 3'd2) || (k == 3'd4);
    isio = (k == 3'd3) || (k == 3'd4);
    inta = (k == 3'd5);
    hi_e = isio ? a[7:0] : a[15:8];
    strb_e = {!(!isw && !inta), !isw, !inta};
    last_i = (four ? 4 : 3) + w;
    @(negedge clk);
    req_kind = k; req_addr = a; req_wdata = wd; req_valid = 1'b1; ready = 1'b0;
    check(req_ready === 1'b1, "R9 ready before accept", req_ready, 1);
    @(negedge clk);
    // R9: scramble request fields after acceptance
    req_valid = 1'b0; req_addr = a ^ 16'h5AA5; req_wdata = ~wd; req_kind = 3'd1;
    for (int i = 0; i <= last_i; i++) begin
      if (i < last_i) begin
        check(rsp_valid === 1'b0, "R4 no early done", rsp_valid, 0);
        check(req_ready === 1'b0, "R9 busy not ready", req_ready, 0);
      end
      if (i == 0) begin
        check(ale === 1'b1 && ad_oe === 1'b1, "R2 ale/oe in T1", {ale, ad_oe}, 2'b11);
        check(ad_out === a[7:0], "R2 low address byte", ad_out, a[7:0]);
        check(a_hi === hi_e, "R2 high address byte", a_hi, hi_e);
        check({io_m, s1, s0} === status_of(k), "R3 status in T1", {io_m, s1, s0}, status_of(k));
        check({rd_n, wr_n, inta_n} === 3'b111, "R5 no strobe in T1", {rd_n, wr_n, inta_n}, 3'b111);
      end else if (i <= 2 + w) begin
        check(ale === 1'b0, "R2 ale one clock", ale, 0);
        check({rd_n, wr_n, inta_n} === strb_e, "R5 R6 strobe window", {rd_n, wr_n, inta_n}, strb_e);
        check({io_m, s1, s0} === status_of(k), "R3 status held", {io_m, s1, s0}, status_of(k));
        if (isw) check(ad_oe === 1'b1 && ad_out === wd, "R7 write data driven", {ad_oe, ad_out}, {1'b1, wd});
        else     check(ad_oe === 1'b0, "R7 lane floated on read", ad_oe, 0);
      end else begin
        check({rd_n, wr_n, inta_n} === 3'b111, "R4 R6 strobe released", {rd_n, wr_n, inta_n}, 3'b111);
        check(ad_oe === 1'b0 && ale === 1'b0, "R4 quiet after strobe", {ad_oe, ale}, 2'b00);
      end
      if (i == last_i) begin
        check(rsp_valid === 1'b1, "R4 R11 done after last T-state", rsp_valid, 1);
        if (!isw) check(rsp_data === rdv, "R8 captured read data", rsp_data, rdv);
      end
      if (i < last_i) begin
        ready = (i >= 1 + w);
        ad_in = (i == 2 + w) ? rdv : ~rdv;
        if (hold_mid && i == 1) hold = 1'b1;
        @(negedge clk);
      end
    end
    ready = 1'b1;
    if (!hold_mid) begin
      @(negedge clk);
      check(rsp_valid === 1'b0, "R11 done one clock", rsp_valid, 0);
      check(req_ready === 1'b1, "R1 idle again", req_ready, 1);
    end
  endtask

  task automatic release_hold();
    req_valid = 1'b1; req_kind = 3'd2;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check(hlda === 1'b1 && ale === 1'b0, "R10 R9 no accept while held", {hlda, ale}, 2'b10);
    end
    req_valid = 1'b0; hold = 1'b0;
    @(negedge clk);
    check(hlda === 1'b0 && req_ready === 1'b1 && bus_oe === 1'b1, "R10 bus returned",
          {hlda, req_ready, bus_oe}, 3'b011);
  endtask

  task automatic test_hold_mid();
    run_cycle(3'd1, 16'h4C21, 8'h00, 8'h96, 1, 1'b1);
    check(hlda === 1'b1, "R10 hlda after cycle", hlda, 1);
    check(bus_oe === 1'b0 && ad_oe === 1'b0, "R10 bus floated", {bus_oe, ad_oe}, 2'b00);
    check({rd_n, wr_n, inta_n, ale} === 4'b1110, "R10 strobes inactive", {rd_n, wr_n, inta_n, ale}, 4'b1110);
    release_hold();
    run_cycle(3'd2, 16'h1234, 8'hC3, 8'h00, 0, 1'b0);
  endtask

  task automatic test_hold_idle();
    @(negedge clk);
    hold = 1'b1; req_valid = 1'b1; req_kind = 3'd0;
    #1;
    check(req_ready === 1'b0, "R9 hold blocks request", req_ready, 0);
    @(negedge clk);
    check(hlda === 1'b1 && bus_oe === 1'b0, "R10 idle handover", {hlda, bus_oe}, 2'b10);
    release_hold();
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_cycle(3'd0, 16'h2005, 8'h00, 8'h4F, 0, 1'b0);  // fetch
    run_cycle(3'd1, 16'h88A7, 8'h00, 8'h3C, 2, 1'b0);  // memory read, 2 waits
    run_cycle(3'd2, 16'hFFF0, 8'hA5, 8'h00, 0, 1'b0);  // memory write
    run_cycle(3'd2, 16'h0102, 8'h5E, 8'h00, 3, 1'b0);  // memory write, 3 waits
    run_cycle(3'd3, 16'hAB30, 8'h00, 8'h71, 1, 1'b0);  // port read
    run_cycle(3'd4, 16'h7750, 8'h19, 8'h00, 0, 1'b0);  // port write
    run_cycle(3'd5, 16'h0000, 8'h00, 8'hEF, 0, 1'b0);  // interrupt acknowledge
    run_cycle(3'd0, 16'hFFFF, 8'h00, 8'h00, 1, 1'b0);  // fetch with wait
    test_hold_mid();
    test_hold_idle();
    run_cycle(3'd3, 16'h0007, 8'h00, 8'hFE, 0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule